// File: doc/BRIEF.md
# Command Stream Method Decoder

This block sits between a command-buffer word fetcher and a method router. It takes a stream of 32-bit words through a valid/ready handshake. Each word is read either as a command header or as an argument of the header before it. Every argument becomes one method write, made of a method number, a subchannel and a 32-bit value. An immediate header also becomes one write, with its payload taken from the header itself. The block counts down the arguments a header announces. It moves the method number according to the stepping policy the header selects: step on every argument, hold, or step once after the first argument.

The control is a two-state machine. `ST_HEADER` waits for a header word. `ST_ARGS` consumes argument words. There are three transitions. **start-burst** goes from `ST_HEADER` to `ST_ARGS` when a header of a stepping mode has a nonzero count. **last-arg** goes from `ST_ARGS` to `ST_HEADER` when the final argument is accepted. **stay-header** keeps `ST_HEADER` for immediate headers, zero-count headers and illegal headers. Writes leave through one output register. Input ready drops whenever that register holds a write the router has not taken. Two one-cycle error pulses report illegal mode codes and an increase-once header with zero arguments.

Top module: `cmd_stream_decoder`

## Requirements
- R1: A header word is split as follows: method in bits 12:0, subchannel in bits 15:13, argument count in bits 28:16 and mode code in bits 31:29. Every write from a header or its arguments carries that header's subchannel.
- R2: For mode codes 0 and 1 (stepping), argument i (counting from 0) is written to method (base + i) modulo 8192. The value of the write is the argument word.
- R3: For mode codes 2 and 3 (fixed), every argument is written to the base method.
- R4: For mode code 5 (step once), the first argument goes to the base method and every later argument goes to (base + 1) modulo 8192.
- R5: For mode code 4 (immediate), the header produces exactly one write to its method. The value is bits 28:16 zero-extended to 32 bits. The next word is parsed as a header.
- R6: A header with mode code 0 to 3 and a count of zero produces no write, and the next word is parsed as a header.
- R7: A header with mode code 5 and a count of zero produces no write. It raises `err_count` for exactly the cycle after it is accepted, and the next word is parsed as a header.
- R8: A header with mode code 6 or 7 produces no write. It raises `err_mode` for exactly the cycle after it is accepted, and the next word is parsed as a header.
- R9: `in_ready` is low whenever `out_valid` is high and `out_ready` is low. A stalled write holds its method, subchannel and value. Writes leave in strict argument order.
- R10: After reset, `out_valid`, `err_mode` and `err_count` are low, `in_ready` is high, and the first accepted word is parsed as a header.
- R11: A write appears on the output in the cycle right after the clock edge that accepts the word causing it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid |
| in_data | input | 32 | Header or argument word |
| in_ready | output | 1 | Decoder accepts the word this cycle |
| out_valid | output | 1 | Method write is valid |
| out_ready | input | 1 | Router takes the write this cycle |
| out_method | output | 13 | Method number of the write |
| out_subch | output | 3 | Subchannel of the write |
| out_value | output | 32 | Value of the write |
| err_mode | output | 1 | One-cycle pulse: illegal mode code |
| err_count | output | 1 | One-cycle pulse: step-once header with zero count |

## Verification
A wrong machine state shows at the ports on the very next accepted word. If the state is lost, an argument is treated as a header: a write goes missing or a spurious error pulse appears. If the state is stuck, a header comes out as a write with the header word as its value. A bad method register or a bad remaining count shows one cycle after the next argument is accepted, as a wrong `out_method` or a burst that ends early or late. The bench keeps a cycle-by-cycle model, so each of these is seen in the cycle it first occurs, including under output stalls.

// File: rtl/csd_pkg.sv
package csd_pkg;

    parameter int WORD_W   = 32;
    parameter int METHOD_W = 13;
    parameter int SUBCH_W  = 3;
    parameter int COUNT_W  = 13;
    parameter int MODE_W   = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_INC_OLD = 3'd0,
        MODE_INC     = 3'd1,
        MODE_FIX_OLD = 3'd2,
        MODE_FIX     = 3'd3,
        MODE_IMM     = 3'd4,
        MODE_ONCE    = 3'd5,
        MODE_BAD6    = 3'd6,
        MODE_BAD7    = 3'd7
    } csd_mode_e;

    typedef enum logic [1:0] {
        STEP_INC,
        STEP_FIX,
        STEP_ONCE
    } csd_step_e;

    typedef enum logic {
        ST_HEADER,
        ST_ARGS
    } csd_state_e;

endpackage

// File: rtl/csd_hdr_decode.sv
module csd_hdr_decode
    import csd_pkg::*;
#(
    parameter int W_WORD   = WORD_W,
    parameter int W_METHOD = METHOD_W,
    parameter int W_SUBCH  = SUBCH_W,
    parameter int W_COUNT  = COUNT_W,
    parameter int W_MODE   = MODE_W
) (
    input  logic [W_WORD-1:0]   word,
    output logic [W_METHOD-1:0] method,
    output logic [W_SUBCH-1:0]  subch,
    output logic [W_COUNT-1:0]  count,
    output logic [W_WORD-1:0]   imm_value,
    output csd_step_e           step,
    output logic                is_imm,
    output logic                is_bad,
    output logic                is_once_zero,
    output logic                is_burst
);
    localparam int SUB_LO   = W_METHOD;
    localparam int CNT_LO   = W_METHOD + W_SUBCH;
    localparam int MODE_LO  = CNT_LO + W_COUNT;

    csd_mode_e mode;
    logic      cnt_zero;

    assign method    = word[SUB_LO-1:0];
    assign subch     = word[CNT_LO-1:SUB_LO];
    assign count     = word[MODE_LO-1:CNT_LO];
    assign mode      = csd_mode_e'(word[MODE_LO+W_MODE-1:MODE_LO]);
    assign imm_value = {{(W_WORD-W_COUNT){1'b0}}, count};
    assign cnt_zero  = (count == '0);

    always_comb begin
        step         = STEP_FIX;
        is_imm       = 1'b0;
        is_bad       = 1'b0;
        is_once_zero = 1'b0;
        is_burst     = 1'b0;
        unique case (mode)
            MODE_INC_OLD, MODE_INC: begin
                step     = STEP_INC;
                is_burst = !cnt_zero;
            end
            MODE_FIX_OLD, MODE_FIX: begin
                step     = STEP_FIX;
                is_burst = !cnt_zero;
            end
            MODE_IMM: begin
                is_imm = 1'b1;
            end
            MODE_ONCE: begin
                step         = STEP_ONCE;
                is_burst     = !cnt_zero;
                is_once_zero = cnt_zero;
            end
            default: begin
                is_bad = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/csd_method_step.sv
module csd_method_step
    import csd_pkg::*;
#(
    parameter int W_METHOD = METHOD_W
) (
    input  csd_step_e           step,
    input  logic [W_METHOD-1:0] cur,
    input  logic [W_METHOD-1:0] base,
    output logic [W_METHOD-1:0] next
);
    localparam logic [W_METHOD-1:0] ONE = {{(W_METHOD-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (step)
            STEP_INC:  next = cur + ONE;
            STEP_ONCE: next = base + ONE;
            default:   next = cur;
        endcase
    end

endmodule

// File: rtl/csd_out_stage.sv
module csd_out_stage #(
    parameter int W_WORD   = 32,
    parameter int W_METHOD = 13,
    parameter int W_SUBCH  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [W_METHOD-1:0] ld_method,
    input  logic [W_SUBCH-1:0]  ld_subch,
    input  logic [W_WORD-1:0]   ld_value,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [W_METHOD-1:0] out_method,
    output logic [W_SUBCH-1:0]  out_subch,
    output logic [W_WORD-1:0]   out_value,
    output logic                slot_free
);
    assign slot_free = !out_valid || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_method <= '0;
            out_subch  <= '0;
            out_value  <= '0;
        end else if (load) begin
            out_valid  <= 1'b1;
            out_method <= ld_method;
            out_subch  <= ld_subch;
            out_value  <= ld_value;
        end else if (out_ready) begin
            out_valid  <= 1'b0;
        end
    end

endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
    import csd_pkg::*;
#(
    parameter int W_WORD   = WORD_W,
    parameter int W_METHOD = METHOD_W,
    parameter int W_SUBCH  = SUBCH_W,
    parameter int W_COUNT  = COUNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [W_WORD-1:0]   in_data,
    output logic                in_ready,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [W_METHOD-1:0] out_method,
    output logic [W_SUBCH-1:0]  out_subch,
    output logic [W_WORD-1:0]   out_value,
    output logic                err_mode,
    output logic                err_count
);
    localparam logic [W_COUNT-1:0] CNT_ONE = {{(W_COUNT-1){1'b0}}, 1'b1};

    csd_state_e state_q, state_d;

    logic [W_METHOD-1:0] base_q, cur_q, cur_next;
    logic [W_SUBCH-1:0]  sub_q;
    logic [W_COUNT-1:0]  rem_q;
    csd_step_e           step_q;

    logic [W_METHOD-1:0] h_method;
    logic [W_SUBCH-1:0]  h_subch;
    logic [W_COUNT-1:0]  h_count;
    logic [W_WORD-1:0]   h_imm;
    csd_step_e           h_step;
    logic                h_imm_en, h_bad, h_once_zero, h_burst;

    logic                accept, slot_free;
    logic                load, start_burst, take_arg;
    logic                err_mode_d, err_count_d;
    logic [W_METHOD-1:0] ld_method;
    logic [W_SUBCH-1:0]  ld_subch;
    logic [W_WORD-1:0]   ld_value;

    csd_hdr_decode #(
        .W_WORD(W_WORD), .W_METHOD(W_METHOD), .W_SUBCH(W_SUBCH),
        .W_COUNT(W_COUNT), .W_MODE(MODE_W)
    ) u_dec (
        .word(in_data), .method(h_method), .subch(h_subch), .count(h_count),
        .imm_value(h_imm), .step(h_step), .is_imm(h_imm_en), .is_bad(h_bad),
        .is_once_zero(h_once_zero), .is_burst(h_burst)
    );

    csd_method_step #(.W_METHOD(W_METHOD)) u_step (
        .step(step_q), .cur(cur_q), .base(base_q), .next(cur_next)
    );

    csd_out_stage #(.W_WORD(W_WORD), .W_METHOD(W_METHOD), .W_SUBCH(W_SUBCH)) u_out (
        .clk(clk), .rst_n(rst_n), .load(load), .ld_method(ld_method),
        .ld_subch(ld_subch), .ld_value(ld_value), .out_ready(out_ready),
        .out_valid(out_valid), .out_method(out_method), .out_subch(out_subch),
        .out_value(out_value), .slot_free(slot_free)
    );

    assign in_ready = slot_free;
    assign accept   = in_valid && slot_free;

    // Next-state and control decode
    always_comb begin
        state_d     = state_q;
        load        = 1'b0;
        start_burst = 1'b0;
        take_arg    = 1'b0;
        err_mode_d  = 1'b0;
        err_count_d = 1'b0;
        ld_method   = cur_q;
        ld_subch    = sub_q;
        ld_value    = in_data;
        unique case (state_q)
            ST_HEADER: begin
                if (accept) begin
                    if (h_bad) begin
                        err_mode_d = 1'b1;
                    end else if (h_imm_en) begin
                        load      = 1'b1;
                        ld_method = h_method;
                        ld_subch  = h_subch;
                        ld_value  = h_imm;
                    end else if (h_once_zero) begin
                        err_count_d = 1'b1;
                    end else if (h_burst) begin
                        start_burst = 1'b1;
                        state_d     = ST_ARGS;
                    end
                end
            end
            ST_ARGS: begin
                if (accept) begin
                    load     = 1'b1;
                    take_arg = 1'b1;
                    if (rem_q == CNT_ONE) begin
                        state_d = ST_HEADER;
                    end
                end
            end
            default: state_d = ST_HEADER;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HEADER;
        end else begin
            state_q <= state_d;
        end
    end

    // Burst bookkeeping and error outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            cur_q     <= '0;
            sub_q     <= '0;
            rem_q     <= '0;
            step_q    <= STEP_FIX;
            err_mode  <= 1'b0;
            err_count <= 1'b0;
        end else begin
            err_mode  <= err_mode_d;
            err_count <= err_count_d;
            if (start_burst) begin
                base_q <= h_method;
                cur_q  <= h_method;
                sub_q  <= h_subch;
                rem_q  <= h_count;
                step_q <= h_step;
            end else if (take_arg) begin
                cur_q <= cur_next;
                rem_q <= rem_q - CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/csd_chk.sv
module csd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [15:0] hdr_top,
    input logic        out_valid,
    input logic        out_ready,
    input logic [12:0] out_method,
    input logic [2:0]  out_subch,
    input logic [31:0] out_value,
    input logic        err_mode,
    input logic        err_count
);
    // R9
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R9
    stall_holds_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_method)
                                       && $stable(out_subch) && $stable(out_value)));

    // R11
    write_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(!out_valid || out_ready)) |-> $past(in_valid && in_ready));

    // R8
    bad_mode_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_mode |-> $past(in_valid && in_ready && hdr_top[15:13] >= 3'd6));

    // R7
    zero_once_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_count |-> $past(in_valid && in_ready && hdr_top[15:13] == 3'd5
                            && hdr_top[12:0] == 13'd0));

    // R7
    err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_mode, err_count}));

endmodule

bind cmd_stream_decoder csd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .hdr_top(in_data[31:16]), .out_valid(out_valid), .out_ready(out_ready),
    .out_method(out_method), .out_subch(out_subch), .out_value(out_value),
    .err_mode(err_mode), .err_count(err_count)
);

// File: tb/tb_cmd_stream_decoder.sv
`timescale 1ns/1ps
module tb_cmd_stream_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [12:0] out_method;
    logic [2:0]  out_subch;
    logic [31:0] out_value;
    logic        err_mode;
    logic        err_count;

    always #2.5 clk = ~clk;

    cmd_stream_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_method(out_method), .out_subch(out_subch), .out_value(out_value),
        .err_mode(err_mode), .err_count(err_count)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    string tag = "R10";
    int    rmode = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    bit          m_hdr = 1'b1;
    int          m_mode, m_rem, m_base, m_cur, m_sub;
    bit          m_ov = 1'b0, m_em = 1'b0, m_ec = 1'b0;
    int          m_om, m_os;
    logic [31:0] m_val;

    function automatic logic [31:0] hdr(int mode, int cnt, int sub, int meth);
        return {mode[2:0], cnt[12:0], sub[2:0], meth[12:0]};
    endfunction

    task automatic check(bit ok, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cycle(bit v, logic [31:0] d, output bit acc);
        bit ld, n_em, n_ec;
        int lm, ls;
        logic [31:0] lv;
        int mo, cnt, sb, me;
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        in_valid = v;
        in_data = d;
        case (rmode)
            0: out_ready = 1'b1;
            1: out_ready = lfsr[0] | lfsr[3];
            default: out_ready = (lfsr[2:0] == 3'd0);
        endcase
        #1;
        check(in_ready == (!m_ov || out_ready), "in_ready", in_ready, !m_ov || out_ready);
        acc = v && (!m_ov || out_ready);
        ld = 0; n_em = 0; n_ec = 0; lm = 0; ls = 0; lv = '0;
        if (acc) begin
            if (m_hdr) begin
                mo = int'(d[31:29]); cnt = int'(d[28:16]);
                sb = int'(d[15:13]); me = int'(d[12:0]);
                if (mo >= 6) n_em = 1;
                else if (mo == 4) begin ld = 1; lm = me; ls = sb; lv = 32'(cnt); end
                else if (cnt == 0) begin if (mo == 5) n_ec = 1; end
                else begin
                    m_hdr = 0; m_mode = mo; m_rem = cnt;
                    m_base = me; m_cur = me; m_sub = sb;
                end
            end else begin
                ld = 1; lm = m_cur; ls = m_sub; lv = d;
                m_rem--;
                if (m_mode <= 1) m_cur = (m_cur + 1) % 8192;
                else if (m_mode == 5) m_cur = (m_base + 1) % 8192;
                if (m_rem == 0) m_hdr = 1;
            end
        end
        @(posedge clk);
        if (ld) begin m_ov = 1; m_om = lm; m_os = ls; m_val = lv; end
        else if (out_ready) m_ov = 0;
        m_em = n_em; m_ec = n_ec;
        #1;
        check(out_valid == m_ov, "out_valid", out_valid, m_ov);
        if (m_ov && out_valid) begin
            check(out_method == 13'(m_om), "out_method", out_method, m_om);
            check(out_subch == 3'(m_os), "out_subch", out_subch, m_os);
            check(out_value == m_val, "out_value", out_value, m_val);
        end
        check(err_mode == m_em, "err_mode", err_mode, m_em);
        check(err_count == m_ec, "err_count", err_count, m_ec);
    endtask

    task automatic send(logic [31:0] w);
        bit acc;
        do cycle(1'b1, w, acc); while (!acc);
    endtask

    task automatic idle(int n);
        bit acc;
        for (int i = 0; i < n; i++) cycle(1'b0, 32'hDEAD_BEEF, acc);
    endtask

    task automatic all_scenarios();
        tag = "R1";
        send(hdr(1, 1, 7, 13'h1FFF)); send(32'h1111_0001);
        send(hdr(3, 2, 5, 13'h0AAA)); send(32'h2); send(32'h3);
        tag = "R2";
        send(hdr(1, 4, 2, 13'h0010));
        for (int i = 0; i < 4; i++) send(32'hA000_0000 + 32'(i));
        send(hdr(0, 3, 1, 13'h0100));
        for (int i = 0; i < 3; i++) send(32'hB000_0000 + 32'(i));
        send(hdr(1, 3, 4, 13'h1FFE));
        for (int i = 0; i < 3; i++) send(32'hC000_0000 + 32'(i));
        tag = "R3";
        send(hdr(3, 3, 6, 13'h0222));
        for (int i = 0; i < 3; i++) send(32'hFFFF_FFF0 + 32'(i));
        send(hdr(2, 2, 0, 13'h0333)); send(32'h5); send(32'h6);
        tag = "R4";
        send(hdr(5, 4, 3, 13'h0040));
        for (int i = 0; i < 4; i++) send(32'hD000_0000 + 32'(i));
        send(hdr(5, 1, 1, 13'h1FFF)); send(32'h77);
        send(hdr(5, 2, 1, 13'h1FFF)); send(32'h78); send(32'h79);
        tag = "R5";
        send(hdr(4, 13'h1ABC, 2, 13'h0555));
        send(hdr(4, 13'h1FFF, 7, 13'h0001));
        send(hdr(1, 1, 0, 13'h0600)); send(32'hE0E0_E0E0);
        tag = "R6";
        send(hdr(1, 0, 2, 13'h0700));
        send(hdr(3, 0, 2, 13'h0701));
        send(hdr(0, 0, 2, 13'h0702));
        send(hdr(4, 3, 2, 13'h0703));
        tag = "R7";
        send(hdr(5, 0, 1, 13'h0800));
        send(hdr(5, 0, 1, 13'h0801));
        send(hdr(3, 1, 1, 13'h0802)); send(32'h9);
        tag = "R8";
        send(hdr(6, 2, 1, 13'h0900));
        send(hdr(7, 0, 1, 13'h0901));
        send(hdr(1, 2, 2, 13'h0902)); send(32'hA); send(32'hB);
        idle(3);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R9 watchdog expired: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        // R10: reset values
        check(out_valid == 1'b0, "reset out_valid", out_valid, 0);
        check(err_mode == 1'b0, "reset err_mode", err_mode, 0);
        check(err_count == 1'b0, "reset err_count", err_count, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(in_ready == 1'b1, "reset in_ready", in_ready, 1);
        // R10: first word after reset is a header (immediate write)
        tag = "R10";
        send(hdr(4, 13'h0123, 1, 13'h0042));
        idle(2);
        // R11: every write is timed by the cycle model
        rmode = 0;
        all_scenarios();
        tag = "R9";
        rmode = 1;
        all_scenarios();
        tag = "R9";
        rmode = 2;
        all_scenarios();
        rmode = 0;
        tag = "R11";
        send(hdr(1, 2, 3, 13'h0ABC)); send(32'h1); send(32'h2);
        idle(4);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule